// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

The block is a synchronous up counter built from 4-bit modulo-16 stages. Each stage can be preset from a data word, cleared, advanced by one or left alone. Which of these happens is fixed by a strict priority: clear first, then preset, then advance, then hold. The top module chains `NSTAGE` stages so that they behave as one binary number of `4*NSTAGE` bits.

Two enables govern counting. `cnt_all` is broadcast to every stage. `cnt_chain` enters the lowest stage only, and each stage forwards it through its own carry output to the stage above. A stage's carry is high while its state is all ones and its chain input is high. The carry path is purely combinational and ignores `cnt_all`. A host can therefore pause the entire counter with `cnt_all`, while ripple of the carry decision stays a single AND per stage.

The parameter `ASYNC_RST` picks the clear style. At its default of 0, a low `rst_n` clears the state on the next rising edge. At 1, a low `rst_n` clears the state at once, with no clock edge. Preset, count and hold logic is the same in both variants. The state output comes straight from the flip-flops.

Top module: `casc_counter`

## Requirements
- R1: While counting, the output `q` rises by exactly one per clock edge as a single unsigned number of `4*NSTAGE` bits, and it wraps from all ones to zero.
- R2: With `ASYNC_RST`=0, a low `rst_n` sampled at a rising edge sets `q` to zero after that edge, whatever `load_n`, `cnt_all` and `cnt_chain` are.
- R3: With `ASYNC_RST`=1, `q` becomes zero as soon as `rst_n` goes low, before any clock edge.
- R4: With `rst_n` high and `load_n` low, `q` takes the value of `din` after the next rising edge, even when both count enables are high.
- R5: With `rst_n` and `load_n` high, `q` advances only when `cnt_all` and `cnt_chain` are both high.
- R6: With `rst_n` and `load_n` high and either count enable low, `q` keeps its value across the edge.
- R7: `carry_out` is high exactly when `cnt_chain` is high and `q` is all ones. It follows `cnt_chain` without waiting for a clock edge and does not depend on `cnt_all`.
- R8: A stage above the lowest one advances only on edges where every stage below it holds 15 and counting is enabled. Crossing from low nibble 15 to 0 therefore carries into the next nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; sync or async per `ASYNC_RST` |
| load_n | input | 1 | Active-low preset enable |
| cnt_all | input | 1 | Count enable broadcast to all stages |
| cnt_chain | input | 1 | Count enable into the lowest stage's carry chain |
| din | input | 4*NSTAGE | Preset value |
| q | output | 4*NSTAGE | Counter state, registered |
| carry_out | output | 1 | Carry out of the top stage |

## Verification
The bench applies clear together with a preset request. A design with the wrong priority would load `din` instead of zero. It presets with both enables high, which exposes a design that advances the loaded value or ignores the preset. It counts across the nibble boundary and across the full wrap. A broken carry chain would leave the upper nibble stuck, or advance it on every edge. It also drops `cnt_chain` at full count and samples `carry_out` before the next edge, and checks `carry_out` with `cnt_all` low. A registered carry would lag there, and a carry that includes `cnt_all` would stay low. A second instance with asynchronous clear must read zero between edges, while the synchronous one still holds its old value.

// File: rtl/casc_counter.sv
module casc_stage #(
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_n,
  input  logic       cnt_all,
  input  logic       chain_in,
  input  logic [3:0] d,
  output logic [3:0] q,
  output logic       chain_out
);
  logic [3:0] nxt;

  always_comb begin
    if (!load_n)                  nxt = d;
    else if (cnt_all && chain_in) nxt = q + 4'd1;
    else                          nxt = q;
  end

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end else begin : g_sync
      always_ff @(posedge clk)
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
  endgenerate

  assign chain_out = chain_in && (q == 4'hF);
endmodule

module casc_counter #(
  parameter int NSTAGE    = 2,
  parameter bit ASYNC_RST = 1'b0,
  localparam int W        = 4 * NSTAGE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         cnt_all,
  input  logic         cnt_chain,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry_out
);
  logic [NSTAGE:0] chain;

  assign chain[0] = cnt_chain;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    casc_stage #(.ASYNC_RST(ASYNC_RST)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_n   (load_n),
      .cnt_all  (cnt_all),
      .chain_in (chain[i]),
      .d        (din[4*i +: 4]),
      .q        (q[4*i +: 4]),
      .chain_out(chain[i+1])
    );
  end

  assign carry_out = chain[NSTAGE];
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n,
  input logic         cnt_all,
  input logic         cnt_chain,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         carry_out
);
  logic armed;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_clear_R2: assert property (@(posedge clk)
    (armed && rst_n && !$past(rst_n)) |-> (q == '0));

  assert_preset_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n) |=> (q == $past(din)));

  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_all && cnt_chain) |=> (q == $past(q) + 1'b1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(cnt_all && cnt_chain)) |=> $stable(q));

  assert_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out == (cnt_chain && (&q)));
endmodule

bind casc_counter casc_counter_chk #(.W(4*NSTAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_all(cnt_all),
  .cnt_chain(cnt_chain), .din(din), .q(q), .carry_out(carry_out)
);

// File: tb/casc_counter_test.sv
module casc_counter_test;
  localparam int NS = 2;
  localparam int W  = 4 * NS;

  logic clk = 1'b0;
  logic rst_n, load_n, cnt_all, cnt_chain;
  logic [W-1:0] din;
  logic [W-1:0] q, qa;
  logic carry_out, carry_a;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  casc_counter #(.NSTAGE(NS), .ASYNC_RST(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_all(cnt_all),
    .cnt_chain(cnt_chain), .din(din), .q(q), .carry_out(carry_out));

  casc_counter #(.NSTAGE(NS), .ASYNC_RST(1'b1)) uut_async (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_all(cnt_all),
    .cnt_chain(cnt_chain), .din(din), .q(qa), .carry_out(carry_a));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic l, input logic ea, input logic ec, input logic [W-1:0] d);
    @(negedge clk);
    rst_n = r; load_n = l; cnt_all = ea; cnt_chain = ec; din = d;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    drive(0, 1, 0, 0, '0); tick(); tick();
    check("R2 reset state", q, '0);
    check("R3 reset state async", qa, '0);
    check("R7 carry idle", {7'd0, carry_out}, '0);
  endtask

  task automatic t_load_over_count();
    drive(1, 0, 1, 1, 8'hA5); tick();
    check("R4 load while counting enabled", q, 8'hA5);
    check("R4 load async variant", qa, 8'hA5);
  endtask

  task automatic t_reset_over_load();
    drive(0, 0, 1, 1, 8'h33); tick();
    check("R2 reset beats load", q, '0);
  endtask

  task automatic t_count_cross();
    drive(1, 0, 0, 0, 8'h0E); tick();
    drive(1, 1, 1, 1, '0); tick();
    check("R1 count 0E->0F", q, 8'h0F);
    tick();
    check("R8 carry into upper nibble", q, 8'h10);
    tick();
    check("R8 upper nibble holds when low nibble not 15", q, 8'h11);
  endtask

  task automatic t_hold();
    drive(1, 1, 0, 1, 8'hFF); tick(); tick();
    check("R6 hold with cnt_all low", q, 8'h11);
    drive(1, 1, 1, 0, 8'hFF); tick();
    check("R5 no count with cnt_chain low", q, 8'h11);
  endtask

  task automatic t_wrap_and_carry();
    drive(1, 0, 0, 0, 8'hFE); tick();
    drive(1, 1, 0, 1, '0); #1;
    check("R7 carry low below full count", {7'd0, carry_out}, '0);
    drive(1, 0, 0, 0, 8'hFF); tick();
    drive(1, 1, 0, 1, '0); #1;
    check("R7 carry high with cnt_all low", {7'd0, carry_out}, 8'd1);
    @(posedge clk); #2;
    cnt_chain = 1'b0; #1;
    check("R7 carry drops with cnt_chain at once", {7'd0, carry_out}, '0);
    drive(1, 1, 1, 1, '0); tick();
    check("R1 wrap all ones to zero", q, '0);
  endtask

  task automatic t_async_clear();
    drive(1, 0, 0, 0, 8'h5A); tick();
    @(negedge clk);
    rst_n = 1'b0; load_n = 1'b1; #1;
    check("R3 async clear before edge", qa, '0);
    check("R2 sync variant waits for edge", q, 8'h5A);
    tick();
    check("R2 sync cleared on edge", q, '0);
    drive(1, 1, 0, 0, '0); tick();
  endtask

  initial begin
    rst_n = 0; load_n = 1; cnt_all = 0; cnt_chain = 0; din = '0;
    t_reset();
    t_load_over_count();
    t_reset_over_load();
    t_count_cross();
    t_hold();
    t_wrap_and_carry();
    t_async_clear();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule